// File: doc/BRIEF.md
# Streaming Bitonic Sorter with One Shared Compare-Exchange Unit

The block sorts frames of `N_KEYS` unsigned keys. `N_KEYS` is a power of two and at least 4. Keys arrive two per cycle on a valid/ready port, so one frame takes `N_KEYS/2` beats. The frame is written into a working buffer. A sequencer then walks the full bitonic network over that buffer, one compare-exchange per cycle, and a single two-input compare-exchange unit does all of the comparisons. The sequencer generates the buffer address pair for each step. This makes the permutation between stages a matter of address generation, so no data is moved between stages.

When the last stage completes, the whole frame is copied into a drain buffer in one cycle. It then streams out two keys per cycle, with a valid flag and a frame-start flag. The input port reopens on the same cycle that draining begins. The next frame can therefore be loaded while the previous one leaves. Keys come out in nondecreasing order by default, and the `DESCEND` parameter reverses the order. The operation sequence is the same for every frame, whatever the data.

Top module: `bitonic_stream_sorter`

## Requirements
- R1: One beat is accepted on each cycle where `in_valid_i` and `in_ready_o` are both high. Within a frame, beat b writes `in_key0_i` to position 2b and `in_key1_i` to position 2b+1. A frame is exactly `N_KEYS/2` accepted beats.
- R2: Each output frame holds the keys of the matching input frame, ordered nondecreasing across positions 0..N_KEYS-1 when `DESCEND`=0. Beat b carries position 2b on `out_key0_o` and position 2b+1 on `out_key1_o`.
- R3: Sorting takes exactly S·N_KEYS/2 compare-exchange cycles, where S = log2(N)·(log2(N)+1)/2. The first output beat appears S·N_KEYS/2+1 cycles after the clock edge that accepts the frame's last beat. For N_KEYS=8 this is 25 cycles.
- R4: The compare direction follows the bitonic rule. For block size 2^k and lower index i, the smaller key goes to the lower index when bit k of i is 0. It goes to the higher index when that bit is 1. `DESCEND`=1 inverts every direction.
- R5: `in_ready_o` stays low from the edge that accepts a frame's last beat until the cycle of that frame's first output beat. Any `in_valid_i` asserted in that window has no effect on any output.
- R6: A new frame can be loaded while the previous frame drains, and the drain continues undisturbed.
- R7: `out_valid_o` stays high for exactly `N_KEYS/2` consecutive cycles per frame. `out_first_o` is high on the first of those cycles only.
- R8: Equal keys are never exchanged. Frames with duplicates, or with all keys equal, come out as the same multiset.
- R9: After reset, `in_ready_o` is 1 and `out_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Block can take a beat |
| in_key0_i | input | KEY_W | Key for even position |
| in_key1_i | input | KEY_W | Key for odd position |
| out_valid_o | output | 1 | Output beat valid |
| out_first_o | output | 1 | First beat of a sorted frame |
| out_key0_o | output | KEY_W | Sorted key, even position |
| out_key1_o | output | KEY_W | Sorted key, odd position |

## Verification
The assertions rely on two assumptions. First, the input presents beats only through the valid/ready handshake. Second, the output side consumes every beat, since the block has no output stall. Sorting always outlasts draining, so the drain buffer is never recaptured while it is still active.

The stimulus respects these assumptions. It presents beats only through the handshake, with random idle gaps. It keeps `in_valid_i` asserted with junk keys while ready is low, which probes R5. Random frames are mixed with directed ones: all keys equal, already sorted, reverse sorted, extreme values, and narrow ranges that are heavy in duplicates.

// File: rtl/bsort_pkg.sv
package bsort_pkg;
  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_SORT = 2'd1,
    PH_COPY = 2'd2
  } phase_e;

  function automatic int unsigned stage_count(input int unsigned log_n);
    return log_n * (log_n + 1) / 2;
  endfunction
endpackage

// File: rtl/bsort_cmp_exch.sv
module bsort_cmp_exch #(
  parameter int KEY_W = 16
) (
  input  logic [KEY_W-1:0] a_i,
  input  logic [KEY_W-1:0] b_i,
  input  logic             min_lo_i,
  output logic [KEY_W-1:0] lo_o,
  output logic [KEY_W-1:0] hi_o
);
  logic swap;
  // strict compare: equal keys stay put
  assign swap = min_lo_i ? (a_i > b_i) : (b_i > a_i);
  assign lo_o = swap ? b_i : a_i;
  assign hi_o = swap ? a_i : b_i;
endmodule

// File: rtl/bsort_seq.sv
module bsort_seq #(
  parameter int N_KEYS  = 8,
  parameter int DESCEND = 0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  output logic                       busy_o,
  output logic                       last_o,
  output logic [$clog2(N_KEYS)-1:0]  idx_lo_o,
  output logic [$clog2(N_KEYS)-1:0]  idx_hi_o,
  output logic                       min_lo_o
);
  localparam int LOG_N  = $clog2(N_KEYS);
  localparam int HALF   = N_KEYS / 2;
  localparam int PAIR_W = LOG_N - 1;
  localparam int BLK_W  = $clog2(LOG_N + 1);
  localparam int STAGES = int'(bsort_pkg::stage_count(LOG_N));
  localparam int TOTAL  = STAGES * HALF;
  localparam int CW     = $clog2(TOTAL + 1);

  logic              busy_q;
  logic [BLK_W-1:0]  blk_q;   // log2 of bitonic block size
  logic [BLK_W-1:0]  dst_q;   // log2 of pair distance
  logic [PAIR_W-1:0] pair_q;
  logic              pair_end;
  logic [LOG_N-1:0]  p_ext, mask, lo, hi;
  logic [LOG_N:0]    lo_ext;
  logic              up;

  assign pair_end = pair_q == PAIR_W'(HALF - 1);
  assign last_o   = busy_q && pair_end && (dst_q == '0) && (blk_q == BLK_W'(LOG_N));
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      blk_q  <= '0;
      dst_q  <= '0;
      pair_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      blk_q  <= BLK_W'(1);
      dst_q  <= '0;
      pair_q <= '0;
    end else if (busy_q) begin
      pair_q <= pair_end ? '0 : pair_q + PAIR_W'(1);
      if (pair_end) begin
        if (dst_q == '0) begin
          if (last_o) busy_q <= 1'b0;
          else begin
            blk_q <= blk_q + BLK_W'(1);
            dst_q <= blk_q;
          end
        end else begin
          dst_q <= dst_q - BLK_W'(1);
        end
      end
    end
  end

  // insert a zero at bit dst_q of the pair number
  always_comb begin
    p_ext  = LOG_N'(pair_q);
    mask   = (LOG_N'(1) << dst_q) - LOG_N'(1);
    lo     = ((p_ext & ~mask) << 1) | (p_ext & mask);
    hi     = lo | (LOG_N'(1) << dst_q);
    lo_ext = {1'b0, lo};
    up     = ~lo_ext[blk_q];
  end

  assign idx_lo_o = lo;
  assign idx_hi_o = hi;
  assign min_lo_o = (DESCEND != 0) ? ~up : up;

  logic [CW-1:0] ce_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_cnt_q <= '0;
    else if (start_i) ce_cnt_q <= '0;
    else if (busy_q) ce_cnt_q <= ce_cnt_q + CW'(1);
  end

  a_r3_stage_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> ce_cnt_q == CW'(TOTAL - 1));
  a_r4_final_merge_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && blk_q == BLK_W'(LOG_N)) |-> (min_lo_o == (DESCEND == 0)));
  a_r3_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i);
endmodule

// File: rtl/bsort_frame_buf.sv
module bsort_frame_buf #(
  parameter int N_KEYS = 8,
  parameter int KEY_W  = 16
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 ld_en_i,
  input  logic [$clog2(N_KEYS)-2:0]            ld_beat_i,
  input  logic [KEY_W-1:0]                     ld_k0_i,
  input  logic [KEY_W-1:0]                     ld_k1_i,
  input  logic                                 ce_en_i,
  input  logic [$clog2(N_KEYS)-1:0]            ce_lo_idx_i,
  input  logic [$clog2(N_KEYS)-1:0]            ce_hi_idx_i,
  input  logic [KEY_W-1:0]                     ce_lo_d_i,
  input  logic [KEY_W-1:0]                     ce_hi_d_i,
  output logic [KEY_W-1:0]                     rd_lo_o,
  output logic [KEY_W-1:0]                     rd_hi_o,
  output logic [N_KEYS-1:0][KEY_W-1:0]         frame_o
);
  localparam int LOG_N  = $clog2(N_KEYS);
  localparam int PAIR_W = LOG_N - 1;

  logic [N_KEYS-1:0][KEY_W-1:0] mem_q;

  for (genvar e = 0; e < N_KEYS; e++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[e] <= '0;
      else if (ld_en_i && ld_beat_i == PAIR_W'(e / 2))
        mem_q[e] <= (e % 2 == 1) ? ld_k1_i : ld_k0_i;
      else if (ce_en_i && ce_lo_idx_i == LOG_N'(e))
        mem_q[e] <= ce_lo_d_i;
      else if (ce_en_i && ce_hi_idx_i == LOG_N'(e))
        mem_q[e] <= ce_hi_d_i;
    end
  end

  assign rd_lo_o = mem_q[ce_lo_idx_i];
  assign rd_hi_o = mem_q[ce_hi_idx_i];
  assign frame_o = mem_q;

  a_r1_port_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_en_i && ce_en_i));
endmodule

// File: rtl/bsort_drain_buf.sv
module bsort_drain_buf #(
  parameter int N_KEYS  = 8,
  parameter int KEY_W   = 16,
  parameter int DESCEND = 0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cap_i,
  input  logic [N_KEYS-1:0][KEY_W-1:0] frame_i,
  output logic                         out_valid_o,
  output logic                         out_first_o,
  output logic [KEY_W-1:0]             out_key0_o,
  output logic [KEY_W-1:0]             out_key1_o
);
  localparam int LOG_N  = $clog2(N_KEYS);
  localparam int HALF   = N_KEYS / 2;
  localparam int PAIR_W = LOG_N - 1;

  logic [N_KEYS-1:0][KEY_W-1:0] hold_q;
  logic                         active_q;
  logic [PAIR_W-1:0]            beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= '0;
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (cap_i) begin
      hold_q   <= frame_i;
      active_q <= 1'b1;
      beat_q   <= '0;
    end else if (active_q) begin
      beat_q <= beat_q + PAIR_W'(1);
      if (beat_q == PAIR_W'(HALF - 1)) active_q <= 1'b0;
    end
  end

  assign out_valid_o = active_q;
  assign out_first_o = active_q && (beat_q == '0);
  assign out_key0_o  = hold_q[{beat_q, 1'b0}];
  assign out_key1_o  = hold_q[{beat_q, 1'b1}];

  a_r6_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |-> !active_q);
  a_r7_rise_is_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> out_first_o);
  a_r7_first_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_first_o |=> !out_first_o);
  a_r2_beat_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((DESCEND != 0) ? (out_key0_o >= out_key1_o) : (out_key0_o <= out_key1_o)));
  a_r2_cross_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_first_o) |->
      ((DESCEND != 0) ? ($past(out_key1_o) >= out_key0_o) : ($past(out_key1_o) <= out_key0_o)));
endmodule

// File: rtl/bitonic_stream_sorter.sv
module bitonic_stream_sorter #(
  parameter int N_KEYS  = 8,
  parameter int KEY_W   = 16,
  parameter int DESCEND = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [KEY_W-1:0] in_key0_i,
  input  logic [KEY_W-1:0] in_key1_i,
  output logic             out_valid_o,
  output logic             out_first_o,
  output logic [KEY_W-1:0] out_key0_o,
  output logic [KEY_W-1:0] out_key1_o
);
  import bsort_pkg::*;

  localparam int LOG_N  = $clog2(N_KEYS);
  localparam int HALF   = N_KEYS / 2;
  localparam int PAIR_W = LOG_N - 1;

  phase_e                       phase_q;
  logic [PAIR_W-1:0]            ld_beat_q;
  logic                         accept, load_last;
  logic                         seq_busy, seq_last, min_lo;
  logic [LOG_N-1:0]             idx_lo, idx_hi;
  logic [KEY_W-1:0]             rd_lo, rd_hi, ce_lo, ce_hi;
  logic [N_KEYS-1:0][KEY_W-1:0] frame;

  assign in_ready_o = (phase_q == PH_LOAD);
  assign accept     = in_valid_i && in_ready_o;
  assign load_last  = accept && (ld_beat_q == PAIR_W'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_LOAD;
      ld_beat_q <= '0;
    end else begin
      if (accept) ld_beat_q <= load_last ? '0 : ld_beat_q + PAIR_W'(1);
      unique case (phase_q)
        PH_LOAD: if (load_last) phase_q <= PH_SORT;
        PH_SORT: if (seq_last)  phase_q <= PH_COPY;
        PH_COPY: phase_q <= PH_LOAD;
        default: phase_q <= PH_LOAD;
      endcase
    end
  end

  bsort_seq #(.N_KEYS(N_KEYS), .DESCEND(DESCEND)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (load_last),
    .busy_o   (seq_busy),
    .last_o   (seq_last),
    .idx_lo_o (idx_lo),
    .idx_hi_o (idx_hi),
    .min_lo_o (min_lo)
  );

  bsort_frame_buf #(.N_KEYS(N_KEYS), .KEY_W(KEY_W)) u_work (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_en_i     (accept),
    .ld_beat_i   (ld_beat_q),
    .ld_k0_i     (in_key0_i),
    .ld_k1_i     (in_key1_i),
    .ce_en_i     (seq_busy),
    .ce_lo_idx_i (idx_lo),
    .ce_hi_idx_i (idx_hi),
    .ce_lo_d_i   (ce_lo),
    .ce_hi_d_i   (ce_hi),
    .rd_lo_o     (rd_lo),
    .rd_hi_o     (rd_hi),
    .frame_o     (frame)
  );

  bsort_cmp_exch #(.KEY_W(KEY_W)) u_ce (
    .a_i      (rd_lo),
    .b_i      (rd_hi),
    .min_lo_i (min_lo),
    .lo_o     (ce_lo),
    .hi_o     (ce_hi)
  );

  bsort_drain_buf #(.N_KEYS(N_KEYS), .KEY_W(KEY_W), .DESCEND(DESCEND)) u_drain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (phase_q == PH_COPY),
    .frame_i     (frame),
    .out_valid_o (out_valid_o),
    .out_first_o (out_first_o),
    .out_key0_o  (out_key0_o),
    .out_key1_o  (out_key1_o)
  );

  a_r5_ready_low_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_busy |-> !in_ready_o);
  a_r5_seq_follows_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_last |=> seq_busy);
  a_r4_min_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_busy && min_lo) |-> ce_lo <= ce_hi);
  a_r4_max_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_busy && !min_lo) |-> ce_lo >= ce_hi);
  a_r8_tie_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_busy && rd_lo == rd_hi) |-> (ce_lo == rd_lo && ce_hi == rd_hi));
  a_r9_reset_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> in_ready_o);
endmodule

// File: tb/sim_bitonic_stream_sorter.sv
`timescale 1ns/1ps
module sim_bitonic_stream_sorter;
  localparam int N    = 8;
  localparam int KW   = 16;
  localparam int HALF = N / 2;
  localparam int LOGN = 3;
  localparam int STG  = LOGN * (LOGN + 1) / 2;
  localparam int M    = STG * HALF;
  localparam int NF   = 40;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic [KW-1:0] in_k0 = '0, in_k1 = '0;
  logic in_ready, out_valid, out_first;
  logic [KW-1:0] out_k0, out_k1;

  always #2 clk = ~clk;

  bitonic_stream_sorter #(.N_KEYS(N), .KEY_W(KW), .DESCEND(0)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_key0_i(in_k0), .in_key1_i(in_k1),
    .out_valid_o(out_valid), .out_first_o(out_first),
    .out_key0_o(out_k0), .out_key1_o(out_k1)
  );

  int total = 0, bad = 0, cyc = 0, of = 0, ob = 0;
  bit done = 1'b0;
  int unsigned exp_k [NF][N];
  int unsigned frm [N];
  int acc_cyc [NF];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic build(input int f);
    for (int i = 0; i < N; i++) begin
      case (f)
        0: frm[i] = 5;
        1: frm[i] = i * 100;
        2: frm[i] = (N - i) * 7;
        3: frm[i] = (i % 2 == 1) ? 16'hffff : 0;
        4: frm[i] = (i % 3 == 0) ? 9 : 2;
        default: frm[i] = (f % 3 == 0) ? ($urandom % 4) : ($urandom & 16'hffff);
      endcase
    end
    for (int i = 0; i < N; i++) exp_k[f][i] = frm[i];
    for (int i = 1; i < N; i++) begin
      for (int j = i; j > 0; j--) begin
        if (exp_k[f][j-1] > exp_k[f][j]) begin
          int unsigned t;
          t = exp_k[f][j]; exp_k[f][j] = exp_k[f][j-1]; exp_k[f][j-1] = t;
        end
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // driver
  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'h5eed_1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R9 valid after reset", out_valid, 0);
    for (int f = 0; f < NF; f++) begin
      int b;
      build(f);
      b = 0;
      while (b < HALF) begin
        @(negedge clk);
        if (in_ready && ($urandom % 5 != 0)) begin
          in_valid = 1'b1;
          in_k0 = KW'(frm[2*b]);
          in_k1 = KW'(frm[2*b+1]);
          b++;
        end else begin
          in_valid = 1'b0;
        end
      end
      @(negedge clk);
      acc_cyc[f] = cyc;
      // junk held valid while blocked must be ignored (R5)
      while (!in_ready) begin
        in_valid = 1'b1;
        in_k0 = KW'($urandom);
        in_k1 = KW'($urandom);
        @(negedge clk);
      end
      in_valid = 1'b0;
      chk(cyc - acc_cyc[f] == M + 1, "R5 ready low window", cyc - acc_cyc[f], M + 1);
      chk(out_valid == 1'b1, "R6 reopen during drain", out_valid, 1);
    end
    while (of < NF) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(of == NF, "R1 frames returned", of, NF);
    chk(out_valid == 1'b0, "R7 idle after last drain", out_valid, 0);
    finish_run();
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && of < NF) begin
        if (out_valid) begin
          chk(out_first == (ob == 0), "R7 first flag", out_first, ob == 0);
          if (ob == 0)
            chk(cyc - acc_cyc[of] == M + 1, "R3 latency", cyc - acc_cyc[of], M + 1);
          chk(out_k0 == KW'(exp_k[of][2*ob]), "R2 R4 R8 key0", out_k0, exp_k[of][2*ob]);
          chk(out_k1 == KW'(exp_k[of][2*ob+1]), "R2 R4 R8 key1", out_k1, exp_k[of][2*ob+1]);
          if (ob == HALF - 1) begin
            ob = 0;
            of++;
          end else ob++;
        end else if (ob != 0) begin
          chk(1'b0, "R7 valid gap", 0, 1);
          ob = 0;
          of++;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end
endmodule